// File: doc/BRIEF.md
# Slow-Clock Seconds Counter with Alarm

This block is a real-time counter for an always-on domain. A 47-bit count advances once per edge of a 32.768 kHz slow clock. The low 15 bits are the fraction of a second and the upper 32 bits are whole seconds. Software reaches the block through a simple register port in the bus-clock domain. It can read the count, load a new count while the counter is stopped, and program a 32-bit seconds alarm. The alarm sets a sticky status flag and, if enabled, an interrupt/wakeup request.

The run bit is written in the bus domain and crosses into the slow domain through synchronizers. The value software reads back is the slow-domain copy after it has returned through a second synchronizer, so software polls the bit to learn when the counter has actually started or stopped. The count reaches the bus domain through a snapshot register. The slow domain flips an update toggle each time the count changes. When the bus domain sees that toggle after synchronization, it copies the whole count, so a read never returns half of an old value and half of a new one.

The register port is a plain control interface. A write takes effect at the clock edge where `wr_en` is high. A read presents its data on `rdata` one cycle after `rd_en`. There is no back-pressure, because every access completes in one cycle.

Top module: `slow_sec_rtc`

## Requirements
- R1: After reset, the control register reads 0, both counter words read 0, the status register reads 0x2 (glitch-pending set, alarm flag clear) and `irq` is low.
- R2: The register map is: control at 0x04, with bit 0 = run, bit 1 = alarm enable and bit 3 = wakeup enable; status at 0x18, with bit 0 = alarm flag and bit 1 = glitch pending; count bits 46:32 in bits 14:0 of 0x1C; count bits 31:0 at 0x20; alarm seconds at 0x24; glitch key at 0x30. Any unmapped offset reads as 0.
- R3: The run bit read back from control bit 0 changes only after the new value has reached the slow domain. It still shows the old value on the read right after the write, and shows the new value within 8 slow-clock periods.
- R4: While running, the count increments by one per slow-clock edge. The low word carries into the high word, and the 47-bit count wraps from all ones to 0.
- R5: A load happens when the low word is written and then the high word is written while the run bit and its read-back are both 0. Writing the low word alone does not change the count. Writes to either count word are ignored while the counter is running.
- R6: Count reads come from a coherent snapshot. While the counter is stopped, repeated reads return identical values equal to the last loaded count.
- R7: The alarm flag sets when the count enters the second (count >> 15) equal to the alarm value while alarm enable is 1. With alarm enable 0, the flag never sets.
- R8: Writes to the alarm register are ignored while alarm enable is 1.
- R9: Writing 1 to status bit 0 clears the alarm flag, and writing 0 leaves it unchanged. If a new match arrives in the same cycle as the clear, the match wins.
- R10: `irq` is high exactly when the alarm flag and wakeup enable are both 1.
- R11: The glitch-pending bit clears only when 0x41736166 is written to the glitch key register. Any other value has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | 32.768 kHz counting clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Alarm interrupt / wakeup request |

## Verification
Counter loads are tried with seeded random 47-bit values, each read back while stopped. This separates a correct load and snapshot path from one that drops or mixes up the two words. Directed loads just below a high-word carry and just below the 47-bit wrap distinguish a correct carry from a truncated counter. Alarm runs start a few ticks before a second boundary, under three settings: alarm enabled, alarm disabled, and wakeup disabled. Together they tell firing at exactly the right second apart from early, late or ungated firing, and the interrupt gate apart from the flag. Wrong glitch keys, zero writes to the status register and alarm writes while the alarm is armed show that those writes have no effect.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
  localparam int ADDR_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 6'h04,
    A_STAT  = 6'h18,
    A_CNTH  = 6'h1C,
    A_CNTL  = 6'h20,
    A_ALRM  = 6'h24,
    A_GUARD = 6'h30
  } reg_addr_e;

  localparam int CTL_RUN    = 0;
  localparam int CTL_ALM    = 1;
  localparam int CTL_WAKE   = 3;
  localparam int ST_ALM     = 0;
  localparam int ST_GLITCH  = 1;
  localparam logic [31:0] GUARD_KEY = 32'h4173_6166;
endpackage

// File: rtl/srtc_sync.sv
module srtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/srtc_slow_core.sv
module srtc_slow_core #(
  parameter int CNT_W       = 47,
  parameter int SYNC_STAGES = 2
) (
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             load_tgl,
  input  logic [CNT_W-1:0] load_val,
  output logic             run_s,
  output logic [CNT_W-1:0] cnt,
  output logic             upd_tgl
);
  logic ld_s, ld_d, load_evt;

  srtc_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(slow_clk), .rst_n(rst_n), .d(run_req), .q(run_s));
  srtc_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
    .clk(slow_clk), .rst_n(rst_n), .d(load_tgl), .q(ld_s));

  assign load_evt = ld_s ^ ld_d;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_d    <= 1'b0;
      cnt     <= '0;
      upd_tgl <= 1'b0;
    end else begin
      ld_d <= ld_s;
      if (load_evt && !run_s) begin
        cnt     <= load_val;
        upd_tgl <= ~upd_tgl;
      end else if (run_s) begin
        cnt     <= cnt + 1'b1;
        upd_tgl <= ~upd_tgl;
      end
    end
  end

  // R5: a stopped counter only changes through a load
  a_r5_hold_when_stopped: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (!run_s && !load_evt) |=> $stable(cnt));
  // R4: every change of the count is announced to the bus domain
  a_r4_update_flagged: assert property (@(posedge slow_clk) disable iff (!rst_n)
    !$stable(cnt) |-> !$stable(upd_tgl));
endmodule

// File: rtl/srtc_alarm.sv
module srtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_evt,
  input  logic [SEC_W-1:0] new_secs,
  input  logic [SEC_W-1:0] old_secs,
  input  logic [SEC_W-1:0] alarm_val,
  input  logic             alarm_en,
  input  logic             clr,
  output logic             flag
);
  logic set_evt;

  // fire on entry into the matching second only
  assign set_evt = snap_evt && alarm_en && (new_secs == alarm_val) && (new_secs != old_secs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  // R7: the flag never rises without alarm enable
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(alarm_en));
  // R9: a clear without a competing match empties the flag
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag);
endmodule

// File: rtl/slow_sec_rtc.sv
module slow_sec_rtc
  import srtc_pkg::*;
#(
  parameter int SUB_W       = 15,
  parameter int SEC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int CNT_W = SUB_W + SEC_W;
  localparam int HI_W  = CNT_W - 32;

  logic             run_bit, alm_en, wake_en, glitch;
  logic [SEC_W-1:0] alarm_val;
  logic [31:0]      load_lo;
  logic [HI_W-1:0]  load_hi;
  logic             load_tgl;
  logic             run_s, run_back;
  logic [CNT_W-1:0] cnt_slow, snap;
  logic             upd_tgl, upd_s, upd_d, snap_evt;
  logic             can_load, clr, flag;
  logic [31:0]      rd_val;

  srtc_slow_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .slow_clk(slow_clk), .rst_n(rst_n), .run_req(run_bit),
    .load_tgl(load_tgl), .load_val({load_hi, load_lo}),
    .run_s(run_s), .cnt(cnt_slow), .upd_tgl(upd_tgl));

  srtc_sync #(.STAGES(SYNC_STAGES)) u_run_back (
    .clk(clk), .rst_n(rst_n), .d(run_s), .q(run_back));
  srtc_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
    .clk(clk), .rst_n(rst_n), .d(upd_tgl), .q(upd_s));

  assign snap_evt = upd_s ^ upd_d;
  assign can_load = !run_bit && !run_back;
  assign clr      = wr_en && (addr == A_STAT) && wdata[ST_ALM];

  // snapshot: the slow count is stable for a whole slow period after its toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_d <= 1'b0;
      snap  <= '0;
    end else begin
      upd_d <= upd_s;
      if (snap_evt) snap <= cnt_slow;
    end
  end

  srtc_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .snap_evt(snap_evt),
    .new_secs(cnt_slow[CNT_W-1:SUB_W]), .old_secs(snap[CNT_W-1:SUB_W]),
    .alarm_val(alarm_val), .alarm_en(alm_en), .clr(clr), .flag(flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_bit   <= 1'b0;
      alm_en    <= 1'b0;
      wake_en   <= 1'b0;
      glitch    <= 1'b1;
      alarm_val <= '0;
      load_lo   <= '0;
      load_hi   <= '0;
      load_tgl  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          run_bit <= wdata[CTL_RUN];
          alm_en  <= wdata[CTL_ALM];
          wake_en <= wdata[CTL_WAKE];
        end
        A_CNTL: if (can_load) load_lo <= wdata;
        A_CNTH: if (can_load) begin
          load_hi  <= wdata[HI_W-1:0];
          load_tgl <= ~load_tgl;
        end
        A_ALRM:  if (!alm_en) alarm_val <= wdata[SEC_W-1:0];
        A_GUARD: if (wdata == GUARD_KEY) glitch <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      A_CTRL: begin
        rd_val[CTL_RUN]  = run_back;
        rd_val[CTL_ALM]  = alm_en;
        rd_val[CTL_WAKE] = wake_en;
      end
      A_STAT: begin
        rd_val[ST_ALM]    = flag;
        rd_val[ST_GLITCH] = glitch;
      end
      A_CNTH: rd_val[HI_W-1:0]  = snap[CNT_W-1:32];
      A_CNTL: rd_val            = snap[31:0];
      A_ALRM: rd_val[SEC_W-1:0] = alarm_val;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign irq = flag && wake_en;

  // R8: an armed alarm keeps its compare value
  a_r8_alarm_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ALRM && alm_en) |=> $stable(alarm_val));
  // R5: load staging is frozen while running
  a_r5_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_CNTL || addr == A_CNTH) && !can_load) |=> ($stable(load_lo) && $stable(load_tgl)));
  // R11: glitch-pending only drops after the key
  a_r11_key_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glitch) |-> $past(wr_en && addr == A_GUARD && wdata == GUARD_KEY));
  // R6: the snapshot only moves on an update event
  a_r6_snap_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(snap_evt) |-> $stable(snap));
endmodule

// File: tb/slow_sec_rtc_bench.sv
module slow_sec_rtc_bench;
  logic        clk = 0, slow_clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_checks = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [5:0] O_CTRL = 6'h04, O_STAT = 6'h18, O_CNTH = 6'h1C,
                         O_CNTL = 6'h20, O_ALRM = 6'h24, O_GUARD = 6'h30;
  localparam int SLOW_NS = 38;

  always #2 clk = ~clk;
  always #(SLOW_NS/2) slow_clk = ~slow_clk;

  slow_sec_rtc u_slow_sec_rtc (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  function automatic logic [46:0] mk(input logic [31:0] secs, input logic [14:0] sub);
    return {secs, sub};
  endfunction

  task automatic rd_cnt(output logic [46:0] v);
    logic [31:0] h, l;
    rd(O_CNTH, h); rd(O_CNTL, l);
    v = {h[14:0], l};
  endtask

  task automatic poll_run(input bit want, input string req, output time took);
    logic [31:0] d;
    time t0 = $time;
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      rd(O_CTRL, d);
      if (d[0] == want) seen = 1;
    end
    took = $time - t0;
    check(seen, req, 64'(took), 64'(8*SLOW_NS));
  endtask

  task automatic load(input logic [46:0] v);
    wr(O_CNTL, v[31:0]);
    wr(O_CNTH, {17'd0, v[46:32]});
    #(6*SLOW_NS);
  endtask

  task automatic stop();
    time t;
    wr(O_CTRL, 0);
    poll_run(0, "R3 stop readback", t);
  endtask

  task automatic wait_flag(output bit seen);
    logic [31:0] d;
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      rd(O_STAT, d);
      if (d[0]) seen = 1;
    end
  endtask

  initial begin
    #(150000*4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [46:0] v, exp, got, delta;
    time t;
    bit seen;
    void'($urandom(32'h5eed_0042));
    #13 rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(O_CTRL, d); check(d == 0, "R1 ctrl", d, 0);
    rd(O_STAT, d); check(d == 32'h2, "R1 status", d, 2);
    rd(O_CNTH, d); check(d == 0, "R1 cnt hi", d, 0);
    rd(O_CNTL, d); check(d == 0, "R1 cnt lo", d, 0);
    check(irq == 0, "R1 irq", irq, 0);

    // R11 glitch key
    wr(O_GUARD, 32'h1234_5678);
    rd(O_STAT, d); check(d[1] == 1, "R11 wrong key", d, 2);
    wr(O_GUARD, 32'h4173_6166);
    rd(O_STAT, d); check(d[1] == 0, "R11 key", d, 0);

    // R2 unmapped offset
    rd(6'h08, d); check(d == 0, "R2 unmapped", d, 0);

    // R3 enable latency
    wr(O_CTRL, 32'h1);
    rd(O_CTRL, d); check(d[0] == 0, "R3 not yet", d, 0);
    poll_run(1, "R3 start readback", t);
    rd_cnt(v);
    #(20*SLOW_NS);
    rd_cnt(got);
    check(got > v, "R4 advancing", got, v);
    // R5 writes while running ignored
    wr(O_CNTL, 32'hABCD_0000); wr(O_CNTH, 32'h5);
    stop();
    #(6*SLOW_NS);
    rd_cnt(got);
    check(got[46:32] == 0, "R5 load while running", got, 0);

    // R5/R6 random loads, read back while stopped
    for (int i = 0; i < 8; i++) begin
      exp = {$urandom(), $urandom()};
      load(exp);
      rd_cnt(got); rd(O_CNTL, d2);
      check(got == exp, "R5 load value", got, exp);
      check(d2 == got[31:0], "R6 repeat read", d2, got[31:0]);
      d = $urandom();
      wr(O_ALRM, d); rd(O_ALRM, d2);
      check(d2 == d, "R2 alarm readback", d2, d);
    end
    // R5 low word alone
    wr(O_CNTL, 32'h0F0F_0F0F); #(6*SLOW_NS);
    rd_cnt(got); check(got == exp, "R5 low only", got, exp);

    // R4 carry into high word
    exp = {15'h12, 32'hFFFF_FFF0};
    load(exp);
    wr(O_CTRL, 1); poll_run(1, "R3 start readback", t);
    #(40*SLOW_NS); stop();
    #(4*SLOW_NS);
    rd_cnt(got); delta = got - exp;
    check(delta >= 30 && delta <= 55, "R4 tick count", delta, 40);
    check(got[46:32] == 15'h13, "R4 carry", got[46:32], 15'h13);

    // R4 47-bit wrap
    exp = {15'h7FFF, 32'hFFFF_FFF0};
    load(exp);
    wr(O_CTRL, 1); poll_run(1, "R3 start readback", t);
    #(40*SLOW_NS); stop();
    #(4*SLOW_NS);
    rd_cnt(got); delta = got - exp;
    check(delta >= 30 && delta <= 55, "R4 wrap tick count", delta, 40);
    check(got[46:32] == 0, "R4 wrap", got[46:32], 0);

    // R7 alarm disabled never fires
    load(mk(32'd5, 15'h7FE0));
    wr(O_ALRM, 32'd6);
    wr(O_CTRL, 32'h9);
    #(70*SLOW_NS);
    rd(O_STAT, d); check(d[0] == 0, "R7 disabled", d, 0);
    check(irq == 0, "R10 no flag", irq, 0);
    stop();

    // R7 fires at the exact second
    load(mk(32'd5, 15'h7FE0));
    rd(O_STAT, d); check(d[0] == 0, "R7 before", d, 0);
    wr(O_CTRL, 32'hB);
    wait_flag(seen);
    check(seen, "R7 fired", seen, 1);
    rd_cnt(got);
    check(got[46:15] == 6, "R7 exact second", got[46:15], 6);
    check(got[14:0] < 15'h20, "R7 early in second", got[14:0], 0);
    check(irq == 1, "R10 irq", irq, 1);
    // R8 armed alarm locked
    wr(O_ALRM, 32'd9); rd(O_ALRM, d); check(d == 6, "R8 locked", d, 6);
    // R9 write-one-to-clear
    wr(O_STAT, 32'h0); rd(O_STAT, d); check(d[0] == 1, "R9 zero write", d, 1);
    wr(O_STAT, 32'h1); rd(O_STAT, d); check(d[0] == 0, "R9 clear", d, 0);
    check(irq == 0, "R10 irq after clear", irq, 0);
    stop();

    // R10 wakeup gate
    load(mk(32'd6, 15'h7FE0));
    wr(O_ALRM, 32'd7);
    wr(O_CTRL, 32'h3);
    wait_flag(seen);
    check(seen, "R7 fired second run", seen, 1);
    check(irq == 0, "R10 wake off", irq, 0);
    wr(O_CTRL, 32'hB);
    check(irq == 1, "R10 wake on", irq, 1);
    stop();

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule